// File: doc/BRIEF.md
# Integer Add/Subtract Execution Unit

This unit performs the add and subtract family of a 64-bit integer core that runs software in 32-bit mode. It covers register-register add and subtract-from, their carrying and extended variants, the add-to-zero and add-to-minus-one variants, negate, and three immediate forms: add immediate, add immediate shifted, and subtract-from immediate. The written result is always the full 64-bit arithmetic value. Carry, overflow and the condition field are all derived from the low 32 bits only.

A decode stage presents one operation per cycle on `in_valid`. The inputs are an opcode, the two register values, a signed 16-bit immediate, the current carry and summary-overflow bits, and the overflow-enable and record flags. One cycle later the unit presents the result and the flag updates. Each flag output has a write enable, and the enable is raised only for operations that define that flag.

Top module: `int_addsub_unit`

## Requirements
- R1: The result is the full 64-bit value of the operation, with the upper 32 bits never truncated or zeroed. For example, negating 5 gives 0xFFFFFFFF_FFFFFFFB.
- R2: Add immediate shifted computes A + (sign-extended imm << 16) over 64 bits. For it and for add immediate, a raised `ra_zero` replaces A with the constant 0.
- R3: For add-carrying (op 1), add-to-zero (op 3) and add immediate carrying (op 11), carry-out is 1 when the 32-bit low-word sum is unsigned less than A's low word. For add-extended (op 2), carry-out is also 1 when that sum equals A's low word and carry-in is 1.
- R4: Subtract-from carrying (op 6, B − A) sets carry when B's low word is unsigned greater than or equal to A's low word. Subtract-from immediate (op 13, imm − A) does the same with the sign-extended immediate's low word in place of B.
- R5: Subtract-from extended (op 7) computes ~A + B + carry-in. Its carry is 1 when B's low word is greater than A's low word, or when the two are equal and carry-in is 1.
- R6: Subtract-from-zero extended (op 8) computes ~A + carry-in and carries only when A's low word is 0 and carry-in is 1. Subtract-from-minus-one extended (op 9) computes ~A + carry-in − 1 and carries when ~A's low word is nonzero or carry-in is 1, so with A's low word 0xFFFFFFFF and carry-in 0 the carry is 0.
- R7: Add-minus-one extended (op 4) computes A + carry-in − 1 and carries when A's low word is nonzero or carry-in is 1.
- R8: For register forms (ops 0 to 10) with `oe` set, `ov_we` is 1. `ov_out` is then the 32-bit signed overflow, meaning the exact signed value differs from the sign-extended low 32 bits of the result, and `so_out` is `so_in` OR that overflow. Without `oe`, and for immediate forms, `ov_we` and `ov_out` are 0 and `so_out` equals `so_in`.
- R9: Negate (op 10) computes 0 − A over 64 bits and flags overflow only when A's low word is 0x80000000.
- R10: When `rc` is set on ops 0 to 11, `cr_we` is 1 and `cr_field` is {LT, GT, EQ, SO} in bits 3 down to 0. LT, GT and EQ come from the signed low 32 bits of the result, and SO equals `so_out`. Otherwise `cr_we` is 0 and `cr_field` is 0.
- R11: `ca_we` is 1 only for ops 1, 2, 3, 4, 6, 7, 8, 9, 11 and 13. When `ca_we` is 0, `ca_out` is 0. The opcode codes are: 0 add, 1 add-carrying, 2 add-extended, 3 add-to-zero, 4 add-minus-one, 5 subtract-from, 6 subtract-from carrying, 7 subtract-from extended, 8 subtract-from-zero, 9 subtract-from-minus-one, 10 negate, 11 add immediate carrying, 12 add immediate shifted, 13 subtract-from immediate, 14 add immediate, 15 reserved. The reserved code gives a zero result with no flag writes.
- R12: Outputs are registered. `out_valid` follows `in_valid` one cycle later, and back-to-back operations produce one result per cycle.
- R13: After reset, `out_valid`, `result` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R11) |
| ra_zero | input | 1 | A field names register 0, so immediate add forms use 0 |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| imm | input | 16 | Signed immediate |
| ca_in | input | 1 | Current carry bit |
| oe | input | 1 | Overflow enable |
| rc | input | 1 | Record to condition field |
| so_in | input | 1 | Current summary overflow |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Full 64-bit result |
| ca_we | output | 1 | Carry write enable |
| ca_out | output | 1 | New carry |
| ov_we | output | 1 | Overflow write enable |
| ov_out | output | 1 | New overflow |
| so_out | output | 1 | New summary overflow |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench targets operands whose upper word is nonzero. A unit that computed flags over 64 bits would then give wrong carries, and one that cleared the upper word would return results such as 0x00000000_FFFFFFFB for negate. It also targets the equal-operand carry edges of the extended forms, plus subtract-from-minus-one with a low word of 0xFFFFFFFF and no carry-in, where a carry taken from a 64-bit inversion would stick at 1. Further cases cover negating 0x80000000, signed overflow at 0x7FFFFFFF + 1, a zero low word under a nonzero upper word for the EQ bit, and immediate forms with `ra_zero`. A design that mishandled these would give a wrong carry, a missing or spurious overflow, or a condition field read from the wrong half. A long random stream then compares every opcode against an independent reference model.

// File: rtl/int_addsub_unit.sv
module int_addsub_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int IMMW = 16,
  parameter int OPW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic            ra_zero,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic            ca_in,
  input  logic            oe,
  input  logic            rc,
  input  logic            so_in,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            ca_we,
  output logic            ca_out,
  output logic            ov_we,
  output logic            ov_out,
  output logic            so_out,
  output logic            cr_we,
  output logic [3:0]      cr_field
);

  localparam logic [OPW-1:0] OP_ADD    = OPW'(0);
  localparam logic [OPW-1:0] OP_ADDC   = OPW'(1);
  localparam logic [OPW-1:0] OP_ADDE   = OPW'(2);
  localparam logic [OPW-1:0] OP_ADDZE  = OPW'(3);
  localparam logic [OPW-1:0] OP_ADDME  = OPW'(4);
  localparam logic [OPW-1:0] OP_SUBF   = OPW'(5);
  localparam logic [OPW-1:0] OP_SUBFC  = OPW'(6);
  localparam logic [OPW-1:0] OP_SUBFE  = OPW'(7);
  localparam logic [OPW-1:0] OP_SUBFZE = OPW'(8);
  localparam logic [OPW-1:0] OP_SUBFME = OPW'(9);
  localparam logic [OPW-1:0] OP_NEG    = OPW'(10);
  localparam logic [OPW-1:0] OP_ADDIC  = OPW'(11);
  localparam logic [OPW-1:0] OP_ADDIS  = OPW'(12);
  localparam logic [OPW-1:0] OP_SUBFIC = OPW'(13);
  localparam logic [OPW-1:0] OP_ADDI   = OPW'(14);

  typedef enum logic [2:0] {Y_B, Y_IMM, Y_IMMSH, Y_ZERO, Y_ONES} ysel_e;

  logic            inv_a, has_ca, has_ov, has_cr, legal;
  logic [1:0]      cin_sel;
  ysel_e           ysel;
  logic [XLEN-1:0] a_eff, x_op, y_op, imm_x, sum;
  logic            cin;
  logic [WLEN:0]   lo_sum;
  logic [WLEN-1:0] lo_nomsb;
  logic            c_out, ov_raw, lt, eq, so_nx;

  assign imm_x = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign a_eff = (ra_zero && (op == OP_ADDI || op == OP_ADDIS)) ? '0 : opa;

  always_comb begin
    inv_a = 1'b0; ysel = Y_B; cin_sel = 2'd0;
    has_ca = 1'b0; has_ov = 1'b1; has_cr = 1'b1; legal = 1'b1;
    unique case (op)
      OP_ADD:    ;
      OP_ADDC:   has_ca = 1'b1;
      OP_ADDE:   begin cin_sel = 2'd2; has_ca = 1'b1; end
      OP_ADDZE:  begin ysel = Y_ZERO; cin_sel = 2'd2; has_ca = 1'b1; end
      OP_ADDME:  begin ysel = Y_ONES; cin_sel = 2'd2; has_ca = 1'b1; end
      OP_SUBF:   begin inv_a = 1'b1; cin_sel = 2'd1; end
      OP_SUBFC:  begin inv_a = 1'b1; cin_sel = 2'd1; has_ca = 1'b1; end
      OP_SUBFE:  begin inv_a = 1'b1; cin_sel = 2'd2; has_ca = 1'b1; end
      OP_SUBFZE: begin inv_a = 1'b1; ysel = Y_ZERO; cin_sel = 2'd2; has_ca = 1'b1; end
      OP_SUBFME: begin inv_a = 1'b1; ysel = Y_ONES; cin_sel = 2'd2; has_ca = 1'b1; end
      OP_NEG:    begin inv_a = 1'b1; ysel = Y_ZERO; cin_sel = 2'd1; end
      OP_ADDIC:  begin ysel = Y_IMM; has_ca = 1'b1; has_ov = 1'b0; end
      OP_ADDIS:  begin ysel = Y_IMMSH; has_ov = 1'b0; has_cr = 1'b0; end
      OP_SUBFIC: begin inv_a = 1'b1; ysel = Y_IMM; cin_sel = 2'd1; has_ca = 1'b1;
                       has_ov = 1'b0; has_cr = 1'b0; end
      OP_ADDI:   begin ysel = Y_IMM; has_ov = 1'b0; has_cr = 1'b0; end
      default:   begin legal = 1'b0; has_ov = 1'b0; has_cr = 1'b0; end
    endcase
  end

  always_comb begin
    unique case (ysel)
      Y_B:     y_op = opb;
      Y_IMM:   y_op = imm_x;
      Y_IMMSH: y_op = imm_x << IMMW;
      Y_ZERO:  y_op = '0;
      default: y_op = '1;
    endcase
  end

  assign cin      = (cin_sel == 2'd1) ? 1'b1 : (cin_sel == 2'd2) ? ca_in : 1'b0;
  assign x_op     = inv_a ? ~a_eff : a_eff;
  assign sum      = x_op + y_op + XLEN'(cin);
  assign lo_sum   = {1'b0, x_op[WLEN-1:0]} + {1'b0, y_op[WLEN-1:0]} + (WLEN+1)'(cin);
  assign lo_nomsb = {1'b0, x_op[WLEN-2:0]} + {1'b0, y_op[WLEN-2:0]} + WLEN'(cin);
  assign c_out    = lo_sum[WLEN];
  assign ov_raw   = lo_nomsb[WLEN-1] ^ c_out;
  assign lt       = sum[WLEN-1];
  assign eq       = (sum[WLEN-1:0] == '0);
  assign so_nx    = so_in | (oe & has_ov & ov_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ca_we     <= 1'b0;
      ca_out    <= 1'b0;
      ov_we     <= 1'b0;
      ov_out    <= 1'b0;
      so_out    <= 1'b0;
      cr_we     <= 1'b0;
      cr_field  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= legal ? sum : '0;
        ca_we    <= has_ca;
        ca_out   <= has_ca & c_out;
        ov_we    <= oe & has_ov;
        ov_out   <= oe & has_ov & ov_raw;
        so_out   <= so_nx;
        cr_we    <= rc & has_cr;
        cr_field <= (rc & has_cr) ? {lt, ~lt & ~eq, eq, so_nx} : 4'b0;
      end
    end
  end

  logic chk_armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (out_valid == $past(in_valid)));

  p_neg_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && $past(op) == OP_NEG) |-> (result == XLEN'(0) - $past(opa)));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && $past(op) == OP_ADDC) |->
      (ca_out == (WLEN'($past(opa[WLEN-1:0]) + $past(opb[WLEN-1:0])) < $past(opa[WLEN-1:0]))));

  p_subf_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && $past(op) == OP_SUBFC) |->
      (ca_out == ($past(opb[WLEN-1:0]) >= $past(opa[WLEN-1:0]))));

  p_subfme_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && $past(op) == OP_SUBFME) |->
      (ca_out == (($past(opa[WLEN-1:0]) != {WLEN{1'b1}}) || $past(ca_in))));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && !$past(oe)) |-> (!ov_we && !ov_out && so_out == $past(so_in)));

  p_so_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_out |-> (so_out && ov_we));

  p_cr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_field[3:1]) == 1 && cr_field[0] == so_out));

  p_flag_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ca_we |-> !ca_out);

endmodule

// File: tb/sim_int_addsub_unit.sv
module sim_int_addsub_unit;
  localparam logic [3:0] ADD = 0, ADDC = 1, ADDE = 2, ADDZE = 3, ADDME = 4, SUBF = 5,
    SUBFC = 6, SUBFE = 7, SUBFZE = 8, SUBFME = 9, NEG = 10, ADDIC = 11, ADDIS = 12,
    SUBFIC = 13, ADDI = 14, RSVD = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, ra_zero = 1'b0, ca_in = 1'b0, oe = 1'b0, rc = 1'b0, so_in = 1'b0;
  logic [3:0] op = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic out_valid, ca_we, ca_out, ov_we, ov_out, so_out, cr_we;
  logic [63:0] result;
  logic [3:0] cr_field;

  always #5 clk = ~clk;

  int_addsub_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ra_zero(ra_zero),
    .opa(opa), .opb(opb), .imm(imm), .ca_in(ca_in), .oe(oe), .rc(rc), .so_in(so_in),
    .out_valid(out_valid), .result(result), .ca_we(ca_we), .ca_out(ca_out), .ov_we(ov_we),
    .ov_out(ov_out), .so_out(so_out), .cr_we(cr_we), .cr_field(cr_field));

  typedef struct {
    logic [63:0] res;
    logic cwe, c, owe, o, so, rwe;
    logic [3:0] cr;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;

  function automatic exp_t model(input logic [3:0] f, input logic [63:0] a, b,
      input logic [15:0] im, input logic ci, ov_en, rec, so, raz, input string tag);
    exp_t e;
    logic [31:0] a32, b32, r32, i32;
    logic [63:0] ex, aa, r;
    longint sa, sb, tsum, sr;
    logic c, hc, ho, hr, o;
    a32 = a[31:0]; b32 = b[31:0];
    sa = $signed(a32); sb = $signed(b32);
    ex = {{48{im[15]}}, im}; i32 = ex[31:0];
    aa = (raz && (f == ADDI || f == ADDIS)) ? 64'd0 : a;
    c = 1'b0; hc = 1'b1; ho = 1'b1; hr = 1'b1; tsum = 0; r = '0;
    case (f)
      ADD:    begin r = a + b; hc = 1'b0; tsum = sa + sb; end
      ADDC:   begin r = a + b; tsum = sa + sb; c = r[31:0] < a32; end
      ADDE:   begin r = a + b + 64'(ci); tsum = sa + sb + longint'(ci);
                    c = (r[31:0] < a32) || (ci && r[31:0] == a32); end
      ADDZE:  begin r = a + 64'(ci); tsum = sa + longint'(ci); c = r[31:0] < a32; end
      ADDME:  begin r = a + 64'(ci) - 64'd1; tsum = sa + longint'(ci) - 1; c = (a32 != 0) || ci; end
      SUBF:   begin r = b - a; hc = 1'b0; tsum = sb - sa; end
      SUBFC:  begin r = b - a; tsum = sb - sa; c = b32 >= a32; end
      SUBFE:  begin r = ~a + b + 64'(ci); tsum = sb - sa - 1 + longint'(ci);
                    c = (b32 > a32) || (b32 == a32 && ci); end
      SUBFZE: begin r = ~a + 64'(ci); tsum = -sa - 1 + longint'(ci); c = (a32 == 0) && ci; end
      SUBFME: begin r = ~a + 64'(ci) - 64'd1; tsum = -sa - 2 + longint'(ci); c = (~a32 != 0) || ci; end
      NEG:    begin r = 64'd0 - a; hc = 1'b0; end
      ADDIC:  begin r = a + ex; ho = 1'b0; c = r[31:0] < a32; end
      ADDIS:  begin r = aa + (ex << 16); hc = 1'b0; ho = 1'b0; hr = 1'b0; end
      SUBFIC: begin r = ex - a; ho = 1'b0; hr = 1'b0; c = i32 >= a32; end
      ADDI:   begin r = aa + ex; hc = 1'b0; ho = 1'b0; hr = 1'b0; end
      default: begin r = '0; hc = 1'b0; ho = 1'b0; hr = 1'b0; end
    endcase
    r32 = r[31:0]; sr = $signed(r32);
    o = (f == NEG) ? (a32 == 32'h8000_0000) : (tsum != sr);
    e.res = r;
    e.cwe = hc; e.c = hc & c;
    e.owe = ov_en & ho; e.o = ov_en & ho & o;
    e.so = so | e.o;
    e.rwe = rec & hr;
    e.cr = e.rwe ? {r32[31], !r32[31] && r32 != 0, r32 == 0, e.so} : 4'b0;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [3:0] f, input logic [63:0] a, b, input logic [15:0] im,
      input logic ci, ov_en, rec, so, raz, input string tag);
    @(negedge clk);
    op = f; opa = a; opb = b; imm = im; ca_in = ci; oe = ov_en; rc = rec; so_in = so;
    ra_zero = raz; in_valid = 1'b1;
    q.push_back(model(f, a, b, im, ci, ov_en, rec, so, raz, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (result !== e.res || ca_we !== e.cwe || ca_out !== e.c || ov_we !== e.owe ||
            ov_out !== e.o || so_out !== e.so || cr_we !== e.rwe || cr_field !== e.cr) begin
          n_bad++;
          $display("FAIL %s actual res=%h cwe=%b c=%b owe=%b o=%b so=%b rwe=%b cr=%b expected res=%h cwe=%b c=%b owe=%b o=%b so=%b rwe=%b cr=%b",
            e.tag, result, ca_we, ca_out, ov_we, ov_out, so_out, cr_we, cr_field,
            e.res, e.cwe, e.c, e.owe, e.o, e.so, e.rwe, e.cr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b0 || result !== 64'd0 || ca_we !== 1'b0 || ov_we !== 1'b0 ||
        so_out !== 1'b0 || cr_we !== 1'b0 || cr_field !== 4'd0) begin
      n_bad++;
      $display("FAIL R13 reset state: actual v=%b res=%h expected all zero", out_valid, result);
    end
    @(negedge clk) rst_n = 1'b1;

    drive(NEG, 64'd5, 0, 0, 0, 0, 0, 0, 0, "R1 neg 5");
    drive(ADD, 64'h1_0000_0000, 64'd1, 0, 0, 0, 0, 0, 0, "R1 add upper");
    drive(ADDC, 64'hFFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, "R1 R3 addc wrap");
    drive(ADDIS, 64'h1234, 0, 16'h8000, 0, 0, 0, 0, 1, "R2 addis ra_zero");
    drive(ADDIS, 64'h10, 0, 16'h0001, 0, 0, 0, 0, 0, "R2 addis reg");
    drive(ADDI, 64'h55, 0, 16'hFFFF, 0, 0, 0, 0, 1, "R2 addi ra_zero");
    drive(ADDI, 64'h55, 0, 16'hFFFF, 0, 0, 0, 0, 0, "R2 addi reg");
    drive(ADDIC, 64'hFFFF_FFFF_0000_0001, 0, 16'hFFFF, 0, 0, 1, 0, 0, "R3 addic upper");
    drive(ADDE, 64'd5, 64'hFFFF_FFFF, 0, 1, 0, 0, 0, 0, "R3 adde equal carry");
    drive(ADDE, 64'd5, 64'd7, 0, 1, 0, 0, 0, 0, "R3 adde no carry");
    drive(ADDZE, 64'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 0, "R3 addze wrap");
    drive(SUBFC, 64'h9, 64'h9, 0, 0, 0, 0, 0, 0, "R4 subfc equal");
    drive(SUBFC, 64'hA, 64'h9, 0, 0, 0, 0, 0, 0, "R4 subfc below");
    drive(SUBFC, 64'hFFFF_FFFF_0000_0001, 64'h2, 0, 0, 0, 0, 0, 0, "R4 subfc upper ignored");
    drive(SUBFIC, 64'd5, 0, 16'hFFFF, 0, 0, 0, 0, 0, "R4 subfic -1");
    drive(SUBFE, 64'h33, 64'h33, 0, 1, 0, 0, 0, 0, "R5 subfe equal ca1");
    drive(SUBFE, 64'h33, 64'h33, 0, 0, 0, 0, 0, 0, "R5 subfe equal ca0");
    drive(SUBFE, 64'h33, 64'h34, 0, 0, 0, 0, 0, 0, "R5 subfe greater");
    drive(SUBFZE, 64'd0, 0, 0, 0, 0, 0, 0, 0, "R6 subfze 0 ca0");
    drive(SUBFZE, 64'd0, 0, 0, 1, 0, 0, 0, 0, "R6 subfze 0 ca1");
    drive(SUBFZE, 64'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 0, "R6 subfze ones ca1");
    drive(SUBFME, 64'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R6 subfme no stick");
    drive(SUBFME, 64'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 0, "R6 subfme ca1");
    drive(ADDME, 64'd0, 0, 0, 0, 0, 0, 0, 0, "R7 addme 0 ca0");
    drive(ADDME, 64'h1_0000_0000, 0, 0, 0, 0, 0, 0, 0, "R7 addme low zero");
    drive(ADDME, 64'd3, 0, 0, 0, 0, 0, 0, 0, "R7 addme nonzero");
    drive(ADD, 64'h7FFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, "R8 add overflow");
    drive(ADD, 64'h7FFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, "R8 add no oe");
    drive(SUBF, 64'd1, 64'h8000_0000, 0, 0, 1, 0, 0, 0, "R8 subf overflow");
    drive(ADD, 64'd1, 64'd2, 0, 0, 1, 0, 1, 0, "R8 so held");
    drive(ADDIC, 64'h7FFF_FFFF, 0, 16'd1, 0, 1, 0, 0, 0, "R8 imm no ov");
    drive(NEG, 64'h8000_0000, 0, 0, 0, 1, 0, 0, 0, "R9 neg min");
    drive(NEG, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, 1, 0, 0, 0, "R9 neg min upper");
    drive(NEG, 64'h8000_0001, 0, 0, 0, 1, 0, 0, 0, "R9 neg no ov");
    drive(ADD, 64'h1_0000_0000, 64'd0, 0, 0, 0, 1, 0, 0, "R10 eq low zero");
    drive(SUBF, 64'd1, 64'd0, 0, 0, 0, 1, 0, 0, "R10 lt");
    drive(ADD, 64'd1, 64'd1, 0, 0, 0, 1, 1, 0, "R10 gt so");
    drive(ADD, 64'h7FFF_FFFF, 64'd1, 0, 0, 1, 1, 0, 0, "R10 lt with ov");
    drive(ADDI, 64'd1, 0, 16'd1, 0, 0, 1, 0, 0, "R10 no record on addi");
    drive(ADD, 64'hFFFF_FFFF, 64'd1, 0, 1, 0, 0, 0, 0, "R11 add no carry write");
    drive(SUBF, 64'd0, 64'd1, 0, 1, 0, 0, 0, 0, "R11 subf no carry write");
    drive(RSVD, 64'd9, 64'd9, 16'd9, 1, 1, 1, 0, 0, "R11 reserved");
    idle();
    idle();
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 idle: actual out_valid=%b expected 0", out_valid);
    end
    for (int i = 0; i < 600; i++) begin
      drive(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom},
        16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
        1'($urandom), "R12 stream");
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R12 missing results: actual %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule